// File: doc/BRIEF.md
# Two-Stage Watchdog Interval Timer

This block is a down-counting watchdog with a small register interface. Software programs a reload value and enables counting. The counter then steps down once on every clock edge that a separate clock-enable input qualifies. When the count hits zero, the block latches a pending-interrupt flag and drives its interrupt output if interrupts are enabled. On the next qualified edge the counter refills itself from the reload value and keeps running.

If software has not acknowledged the interrupt by the following expiry, and reset generation is enabled, the block raises a reset request. That request stays high until the block itself is reset. With reset generation turned off, the block is a plain periodic interval timer. An acknowledge write clears the pending flag and restarts the count, so software that services the interrupt in time keeps the reset away.

Top module: `tmr_watchdog`

## Requirements
- R1: After reset, the interrupt and reset-request outputs are 0, both control bits read 0, and both the reload register and the counter hold all ones of the counter width.
- R2: Read decode by byte offset: 0x0 returns the reload value, 0x4 returns the live counter, 0x8 returns the control bits with the reset enable in bit 1 and the interrupt enable in bit 0, and any other offset, including 0xC, returns 0. Counter-width values are zero-extended.
- R3: While the interrupt enable is 1, the counter decreases by exactly one on each rising edge where the clock-enable input is high. It holds on edges where that input is low.
- R4: While the interrupt enable is 0, the counter holds its value. A control write that changes the interrupt enable from 0 to 1 loads the counter from the reload register.
- R5: The counter steps from 1 to 0 on an enabled edge, and that same edge sets the pending flag. The interrupt output equals the pending flag ANDed with the interrupt enable. The next enabled edge refills the counter from the reload register, so one period lasts reload+1 enabled edges.
- R6: A write to offset 0x0 stores the reload value and loads the counter with it on the same edge. This takes precedence over counting.
- R7: A written reload value of 0 is stored and used as 1.
- R8: A write of any data to offset 0xC clears the pending flag and loads the counter from the reload register.
- R9: If an expiry occurs while the pending flag is already set and the reset enable is 1, the reset-request output goes to 1. With the reset enable at 0, or with the flag cleared before that expiry, it stays 0.
- R10: Once the reset-request output is 1, it remains 1 through any register writes until the block's reset input is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_en | input | 1 | Qualifies the clock edges on which the counter advances |
| reg_wr | input | 1 | Register write strobe, sampled on the rising edge |
| reg_addr | input | ADDR_W | Register byte offset, for both reads and writes |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Combinational read data for reg_addr |
| irq | output | 1 | Interrupt output |
| wdt_rst | output | 1 | Sticky reset request |

## Verification
The bench builds the block with a 16-bit counter on a 32-bit data bus and a 4-bit offset. The narrower counter makes the reset value (0xFFFF) checkable and shows that upper write bits are dropped. It also lets a full-scale reload run to expiry in about 65 thousand edges. Small reload values of 1 to 20 bring repeated expiries, the second-expiry reset and the acknowledge race into a few dozen cycles. This makes every edge of a period checkable against the reload+1 rule.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  // byte offsets; the reset-enable and interrupt-enable bit positions are fixed
  localparam int unsigned OFS_RELOAD = 0;
  localparam int unsigned OFS_COUNT  = 4;
  localparam int unsigned OFS_CTRL   = 8;
  localparam int unsigned OFS_ACK    = 12;
  localparam int unsigned BIT_IRQEN  = 0;
  localparam int unsigned BIT_RSTEN  = 1;
endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
#(
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic [CNT_W-1:0]  cnt_val,
  output logic [CNT_W-1:0]  reload_q,
  output logic [CNT_W-1:0]  reload_d,
  output logic              irq_en,
  output logic              rst_en,
  output logic              wr_reload,
  output logic              wr_ack,
  output logic              en_rise,
  output logic [DATA_W-1:0] reg_rdata
);
  // a zero reload would stall the counter at zero: use 1 instead
  function automatic logic [CNT_W-1:0] fix_reload(input logic [CNT_W-1:0] v);
    return (v == '0) ? CNT_W'(1) : v;
  endfunction

  logic sel_reload, sel_count, sel_ctrl, sel_ack, wr_ctrl;

  assign sel_reload = (reg_addr == ADDR_W'(OFS_RELOAD));
  assign sel_count  = (reg_addr == ADDR_W'(OFS_COUNT));
  assign sel_ctrl   = (reg_addr == ADDR_W'(OFS_CTRL));
  assign sel_ack    = (reg_addr == ADDR_W'(OFS_ACK));

  assign wr_reload = reg_wr && sel_reload;
  assign wr_ctrl   = reg_wr && sel_ctrl;
  assign wr_ack    = reg_wr && sel_ack;
  assign en_rise   = wr_ctrl && reg_wdata[BIT_IRQEN] && !irq_en;
  assign reload_d  = fix_reload(reg_wdata[CNT_W-1:0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload_q <= '1;
      irq_en   <= 1'b0;
      rst_en   <= 1'b0;
    end else begin
      if (wr_reload) reload_q <= reload_d;
      if (wr_ctrl) begin
        irq_en <= reg_wdata[BIT_IRQEN];
        rst_en <= reg_wdata[BIT_RSTEN];
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (sel_reload) begin
      reg_rdata = DATA_W'(reload_q);
    end else if (sel_count) begin
      reg_rdata = DATA_W'(cnt_val);
    end else if (sel_ctrl) begin
      reg_rdata[BIT_IRQEN] = irq_en;
      reg_rdata[BIT_RSTEN] = rst_en;
    end
  end
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_en,
  input  logic             run,
  input  logic             wr_reload,
  input  logic [CNT_W-1:0] reload_d,
  input  logic             restart,
  input  logic [CNT_W-1:0] reload_q,
  output logic [CNT_W-1:0] cnt_q,
  output logic             cnt_wr,
  output logic             expire
);
  // one enabled step: refill at zero, otherwise count down
  function automatic logic [CNT_W-1:0] step(input logic [CNT_W-1:0] c,
                                            input logic [CNT_W-1:0] r);
    return (c == '0) ? r : c - CNT_W'(1);
  endfunction

  logic advance;

  assign cnt_wr  = wr_reload || restart;
  assign advance = !cnt_wr && run && cnt_en;
  assign expire  = advance && (cnt_q == CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt_q <= '1;
    else if (wr_reload) cnt_q <= reload_d;
    else if (restart)   cnt_q <= reload_q;
    else if (advance)   cnt_q <= step(cnt_q, reload_q);
  end
endmodule

// File: rtl/wdt_status.sv
module wdt_status (
  input  logic clk,
  input  logic rst_n,
  input  logic expire,
  input  logic wr_ack,
  input  logic irq_en,
  input  logic rst_en,
  output logic pend_q,
  output logic irq,
  output logic wdt_rst
);
  logic second_hit;

  assign second_hit = expire && pend_q && rst_en;
  assign irq        = pend_q && irq_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= 1'b0;
      wdt_rst <= 1'b0;
    end else begin
      if (expire)      pend_q <= 1'b1;
      else if (wr_ack) pend_q <= 1'b0;
      if (second_hit)  wdt_rst <= 1'b1;
    end
  end
endmodule

// File: rtl/tmr_watchdog.sv
module tmr_watchdog #(
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cnt_en,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq,
  output logic              wdt_rst
);
  logic [CNT_W-1:0] reload_q, reload_d, cnt_q;
  logic irq_en, rst_en, wr_reload, wr_ack, en_rise;
  logic cnt_wr, expire, pend_q, restart;

  assign restart = en_rise || wr_ack;

  wdt_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .cnt_val(cnt_q), .reload_q(reload_q),
    .reload_d(reload_d), .irq_en(irq_en), .rst_en(rst_en),
    .wr_reload(wr_reload), .wr_ack(wr_ack), .en_rise(en_rise),
    .reg_rdata(reg_rdata)
  );

  wdt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .run(irq_en),
    .wr_reload(wr_reload), .reload_d(reload_d), .restart(restart),
    .reload_q(reload_q), .cnt_q(cnt_q), .cnt_wr(cnt_wr), .expire(expire)
  );

  wdt_status u_stat (
    .clk(clk), .rst_n(rst_n), .expire(expire), .wr_ack(wr_ack),
    .irq_en(irq_en), .rst_en(rst_en), .pend_q(pend_q), .irq(irq),
    .wdt_rst(wdt_rst)
  );
endmodule

// File: rtl/wdt_checker.sv
module wdt_checker #(
  parameter int unsigned CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cnt_en,
  input logic             irq_en,
  input logic             rst_en,
  input logic             cnt_wr,
  input logic             pend_q,
  input logic             irq,
  input logic             wdt_rst,
  input logic [CNT_W-1:0] cnt_q,
  input logic [CNT_W-1:0] reload_q
);
  p_step_down_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_en && cnt_en && !cnt_wr && cnt_q != '0) |=> cnt_q == $past(cnt_q) - CNT_W'(1));

  p_hold_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_en && !cnt_wr) |=> $stable(cnt_q));

  p_refill_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_en && cnt_en && !cnt_wr && cnt_q == '0) |=> cnt_q == $past(reload_q));

  p_irq_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (irq_en && pend_q));

  p_nonzero_reload_r7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |-> reload_q != '0);

  p_rst_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wdt_rst) |-> ($past(pend_q) && $past(rst_en)));

  p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_rst |=> wdt_rst);
endmodule

bind tmr_watchdog wdt_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .irq_en(irq_en),
  .rst_en(rst_en), .cnt_wr(cnt_wr), .pend_q(pend_q), .irq(irq),
  .wdt_rst(wdt_rst), .cnt_q(cnt_q), .reload_q(reload_q)
);

// File: tb/sim_tmr_watchdog.sv
`timescale 1ns/1ps
module sim_tmr_watchdog;
  localparam int unsigned CW = 16;
  localparam int unsigned DW = 32;
  localparam int unsigned AW = 4;

  logic clk = 1'b0;
  logic rst_n, cnt_en, reg_wr;
  logic [AW-1:0] reg_addr;
  logic [DW-1:0] reg_wdata, reg_rdata;
  logic irq, wdt_rst;
  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  tmr_watchdog #(.CNT_W(CW), .DATA_W(DW), .ADDR_W(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq(irq), .wdt_rst(wdt_rst)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0; cnt_en = 1'b1;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
    reg_addr = a;
    #0.5;
    d = reg_rdata;
  endtask

  task automatic edges(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [DW-1:0] v;
    do_reset();
    check("R1 irq", 32'(irq), 0);
    check("R1 wdt_rst", 32'(wdt_rst), 0);
    rd(4'h0, v); check("R1 reload", v, 32'hFFFF);
    rd(4'h4, v); check("R1 count", v, 32'hFFFF);
    rd(4'h8, v); check("R1 ctrl", v, 0);
    rd(4'hC, v); check("R2 ack offset reads 0", v, 0);
  endtask

  task automatic t_regmap();
    logic [DW-1:0] v;
    do_reset();
    wr(4'h8, 32'hFFFF_FFFE);
    rd(4'h8, v); check("R2 ctrl bit1 reset-en only", v, 2);
    wr(4'h0, 32'hABCD_1234);
    rd(4'h0, v); check("R2 reload upper bits dropped", v, 32'h1234);
    rd(4'h2, v); check("R2 unmapped offset", v, 0);
    edges(3);
    rd(4'h4, v); check("R4 held while irq-en 0", v, 32'h1234);
  endtask

  task automatic t_count();
    logic [DW-1:0] v;
    do_reset();
    wr(4'h0, 10);
    edges(3);
    rd(4'h4, v); check("R4 hold", v, 10);
    wr(4'h8, 1);
    rd(4'h4, v); check("R4 enable reloads", v, 10);
    edges(3);
    rd(4'h4, v); check("R3 three steps", v, 7);
    cnt_en = 1'b0; edges(4);
    rd(4'h4, v); check("R3 hold when cnt_en low", v, 7);
    cnt_en = 1'b1; edges(2);
    rd(4'h4, v); check("R3 resume", v, 5);
  endtask

  task automatic t_expiry();
    logic [DW-1:0] v;
    do_reset();
    wr(4'h0, 4);
    wr(4'h8, 1);
    edges(3);
    rd(4'h4, v); check("R5 count before zero", v, 1);
    check("R5 irq low before zero", 32'(irq), 0);
    edges(1);
    rd(4'h4, v); check("R5 count at zero", v, 0);
    check("R5 irq at zero", 32'(irq), 1);
    edges(1);
    rd(4'h4, v); check("R5 refill", v, 4);
    check("R5 irq stays pending", 32'(irq), 1);
    wr(4'h8, 0);
    check("R5 irq gated by enable", 32'(irq), 0);
    wr(4'h8, 1);
    check("R5 pending flag kept", 32'(irq), 1);
  endtask

  task automatic t_reload_write();
    logic [DW-1:0] v;
    do_reset();
    wr(4'h0, 20);
    wr(4'h8, 1);
    edges(5);
    rd(4'h4, v); check("R6 running", v, 15);
    wr(4'h0, 7);
    rd(4'h4, v); check("R6 immediate restart", v, 7);
    edges(1);
    rd(4'h4, v); check("R6 counts from new value", v, 6);
  endtask

  task automatic t_zero();
    logic [DW-1:0] v;
    do_reset();
    wr(4'h0, 0);
    rd(4'h0, v); check("R7 reload 0 stored as 1", v, 1);
    rd(4'h4, v); check("R7 count 1", v, 1);
    wr(4'h8, 1);
    edges(1);
    check("R7 expiry after one step", 32'(irq), 1);
    edges(1);
    rd(4'h4, v); check("R7 refill to 1", v, 1);
  endtask

  task automatic t_ack();
    logic [DW-1:0] v;
    do_reset();
    wr(4'h0, 3);
    wr(4'h8, 3);
    edges(3);
    check("R8 pending before ack", 32'(irq), 1);
    edges(1);
    wr(4'hC, 32'h5A5A);
    check("R8 ack clears irq", 32'(irq), 0);
    rd(4'h4, v); check("R8 ack reloads", v, 3);
    edges(3);
    check("R8 new expiry after ack", 32'(irq), 1);
    check("R9 no reset after ack", 32'(wdt_rst), 0);
  endtask

  task automatic t_interval();
    do_reset();
    wr(4'h0, 3);
    wr(4'h8, 1);
    edges(20);
    check("R9 reset-en 0 gives no reset", 32'(wdt_rst), 0);
    check("R9 interval irq", 32'(irq), 1);
  endtask

  task automatic t_reset_out();
    do_reset();
    wr(4'h0, 3);
    wr(4'h8, 3);
    edges(6);
    check("R9 no reset before second expiry", 32'(wdt_rst), 0);
    edges(1);
    check("R9 reset on second expiry", 32'(wdt_rst), 1);
    wr(4'hC, 0);
    wr(4'h8, 0);
    wr(4'h0, 9);
    edges(5);
    check("R10 reset sticky", 32'(wdt_rst), 1);
    do_reset();
    check("R10 cleared by block reset", 32'(wdt_rst), 0);
  endtask

  task automatic t_full();
    logic [DW-1:0] v;
    do_reset();
    wr(4'h0, 32'hFFFF);
    wr(4'h8, 1);
    edges(65534);
    rd(4'h4, v); check("R3 full-scale count", v, 1);
    check("R5 full-scale not yet expired", 32'(irq), 0);
    edges(1);
    check("R5 full-scale expiry", 32'(irq), 1);
  endtask

  initial begin
    rst_n = 1'b0; cnt_en = 1'b1; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    t_reset();
    t_regmap();
    t_count();
    t_expiry();
    t_reload_write();
    t_zero();
    t_ack();
    t_interval();
    t_reset_out();
    t_full();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #600000;
    total++;
    bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule